// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a general-purpose timer together with the up-counter that drives it. The counter steps from zero towards a programmable period limit, returns to zero after reaching it, and signals a wrap in that cycle. A comparator checks the count against a compare value and reports both equality and greater-than. A 3-bit mode selects how a reference level reacts to those results. The level can stay frozen, be set, cleared or toggled on a match, be forced low or high, or follow one of two pulse-width-modulated shapes.

The same output controller serves every mode. Only the two PWM modes take the level back to its starting value at the wrap. The other modes ignore the wrap and keep their level until the next match, a forced mode, or a software preset. The reference drives a pin output that can be gated off and inverted. Two sticky flags record matches and wraps, and each flag has its own single-cycle clear.

Top module: `tmr_oc_channel`

## Requirements
- R1: With `en` high, `cnt_o` rises by one per clock. In a cycle where `cnt_o` is greater than or equal to `reload_val`, the next value is 0. With `en` low, `cnt_o` holds. A wrap is a cycle with `en` high and `cnt_o` >= `reload_val`.
- R2: A wrap sets `upd_flag` at the next edge. A one-cycle `upd_clr` clears it at the next edge. A wrap in the same cycle as the clear wins.
- R3: A match is a cycle with `en` high and `cnt_o == cmp_val`. It sets `match_flag` at the next edge. `match_clr` clears the flag, and a match in the same cycle as the clear wins.
- R4: Mode 3'b000 (frozen): `ref_o` holds its level through matches and wraps.
- R5: In modes 3'b001, 3'b010 and 3'b011, `ref_o` goes high, goes low, or inverts in the cycle after a match. A wrap alone never changes it.
- R6: Mode 3'b100 drives `ref_o` low and mode 3'b101 drives it high, both in the same cycle the mode is applied.
- R7: In mode 3'b110, `ref_o` is 0 while `cnt_o < cmp_val` and 1 otherwise, in the same cycle. Mode 3'b111 gives the inverse. So the level changes at the match and again at the wrap.
- R8: If `cmp_val` > `reload_val`, no match ever occurs. Mode 3'b110 then stays low and mode 3'b111 stays high.
- R9: In modes 3'b000 to 3'b011, a `preset_stb` pulse loads `preset_lvl` into `ref_o` at the next edge, and it wins over a same-cycle match. In modes 3'b100 to 3'b111 the pulse is ignored.
- R10: `pin_o` equals `ref_o` XOR `out_pol` while `pin_en` is high, and 0 while `pin_en` is low.
- R11: Reset clears `cnt_o`, both flags and `ref_o`.
- R12: A switch from a forced or PWM mode to frozen keeps the last level that `ref_o` showed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| reload_val | input | CNT_W | Period limit |
| cmp_val | input | CNT_W | Compare value |
| mode | input | 3 | Output controller mode |
| out_pol | input | 1 | Pin inversion |
| pin_en | input | 1 | Connects reference to pin |
| preset_stb | input | 1 | Load reference level (non-PWM, non-forced modes) |
| preset_lvl | input | 1 | Level for preset |
| match_clr | input | 1 | Clear match flag |
| upd_clr | input | 1 | Clear wrap flag |
| cnt_o | output | CNT_W | Counter value |
| ref_o | output | 1 | Reference level |
| pin_o | output | 1 | Polarity-adjusted, gated pin |
| match_flag | output | 1 | Sticky match flag |
| upd_flag | output | 1 | Sticky wrap flag |

## Verification
The counter properties assume that `reload_val` does not change while a step of the count is being judged. The hold properties for the compare modes assume that `mode` stays constant across the two cycles they span. The stimulus changes `reload_val` and `cmp_val` only while the block is held in reset. It changes `mode` only on cycle boundaries that the hold property exempts, because that property requires a stable mode. Presets and clears are one-cycle pulses, applied while `en` is high and outside the wrap cycle unless a test aims at the set-wins case.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
   typedef enum logic [2:0] {
      OC_FROZEN   = 3'b000,
      OC_SET      = 3'b001,
      OC_CLR      = 3'b010,
      OC_TOG      = 3'b011,
      OC_FORCE_LO = 3'b100,
      OC_FORCE_HI = 3'b101,
      OC_PWM_A    = 3'b110,
      OC_PWM_B    = 3'b111
   } oc_mode_e;

   localparam int FLAG_N = 2;
   localparam int FLAG_MATCH = 0;
   localparam int FLAG_UPD   = 1;
endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] reload,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] ONE = W'(1);

   assign wrap = en && (cnt >= reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (en)   cnt <= cnt + ONE;
   end
endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
   parameter int W = 8
) (
   input  logic         en,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp,
   output logic         eq,
   output logic         gt,
   output logic         match
);
   assign eq    = (cnt == cmp);
   assign gt    = (cnt > cmp);
   assign match = en && eq;
endmodule

// File: rtl/tmr_oc_outctl.sv
module tmr_oc_outctl
   import tmr_oc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       match,
   input  logic       eq,
   input  logic       gt,
   input  logic       preset_stb,
   input  logic       preset_lvl,
   output logic       ref_o
);
   oc_mode_e md;
   logic     lvl_q;
   logic     lvl_d;
   logic     ge;

   assign md = oc_mode_e'(mode);
   assign ge = eq | gt;

   always_comb begin
      unique case (md)
         OC_FORCE_LO: ref_o = 1'b0;
         OC_FORCE_HI: ref_o = 1'b1;
         OC_PWM_A:    ref_o = ge;
         OC_PWM_B:    ref_o = ~ge;
         default:     ref_o = lvl_q;
      endcase
   end

   always_comb begin
      lvl_d = lvl_q;
      if (mode[2]) begin
         lvl_d = ref_o;
      end else if (preset_stb) begin
         lvl_d = preset_lvl;
      end else if (match) begin
         unique case (md)
            OC_SET:  lvl_d = 1'b1;
            OC_CLR:  lvl_d = 1'b0;
            OC_TOG:  lvl_d = ~lvl_q;
            default: lvl_d = lvl_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_d;
   end
endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
   import tmr_oc_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit HAS_PIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [2:0]       mode,
   input  logic             out_pol,
   input  logic             pin_en,
   input  logic             preset_stb,
   input  logic             preset_lvl,
   input  logic             match_clr,
   input  logic             upd_clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ref_o,
   output logic             pin_o,
   output logic             match_flag,
   output logic             upd_flag
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_oc_channel: CNT_W must lie in 2..32");
      end
   endgenerate

   logic              wrap, eq, gt, match;
   logic [FLAG_N-1:0] f_set, f_clr, f_q;

   tmr_oc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en), .reload(reload_val),
      .cnt(cnt_o), .wrap(wrap)
   );

   tmr_oc_compare #(.W(CNT_W)) u_cmp (
      .en(en), .cnt(cnt_o), .cmp(cmp_val),
      .eq(eq), .gt(gt), .match(match)
   );

   tmr_oc_outctl u_out (
      .clk(clk), .rst_n(rst_n), .mode(mode), .match(match), .eq(eq), .gt(gt),
      .preset_stb(preset_stb), .preset_lvl(preset_lvl), .ref_o(ref_o)
   );

   assign f_set[FLAG_MATCH] = match;
   assign f_clr[FLAG_MATCH] = match_clr;
   assign f_set[FLAG_UPD]   = wrap;
   assign f_clr[FLAG_UPD]   = upd_clr;

   generate
      for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         f_q[g] <= 1'b0;
            else if (f_set[g])  f_q[g] <= 1'b1;
            else if (f_clr[g])  f_q[g] <= 1'b0;
         end
      end
   endgenerate

   assign match_flag = f_q[FLAG_MATCH];
   assign upd_flag   = f_q[FLAG_UPD];

   generate
      if (HAS_PIN) begin : g_pin
         assign pin_o = pin_en & (ref_o ^ out_pol);
      end else begin : g_nopin
         logic unused_pin;
         assign unused_pin = pin_en ^ out_pol;
         assign pin_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk #(
   parameter int CNT_W   = 8,
   parameter bit HAS_PIN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [CNT_W-1:0] reload_val,
   input logic [CNT_W-1:0] cmp_val,
   input logic [2:0]       mode,
   input logic             out_pol,
   input logic             pin_en,
   input logic             preset_stb,
   input logic             match_clr,
   input logic             upd_clr,
   input logic [CNT_W-1:0] cnt_o,
   input logic             ref_o,
   input logic             pin_o,
   input logic             match_flag,
   input logic             upd_flag
);
   p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      en && (cnt_o >= reload_val) |=> cnt_o == '0);
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      en && (cnt_o < reload_val) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_o));
   p_upd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && (cnt_o >= reload_val) |=> upd_flag);
   p_upd_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_clr && !(en && (cnt_o >= reload_val)) |=> !upd_flag);
   p_match_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en && (cnt_o == cmp_val) |=> match_flag);
   p_match_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      match_clr && !(en && (cnt_o == cmp_val)) |=> !match_flag);
   p_oc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[2] && !preset_stb && !(en && (cnt_o == cmp_val))) ##1 (!mode[2] && $stable(mode))
      |-> $stable(ref_o));
   p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'b100 |-> !ref_o);
   p_force_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'b101 |-> ref_o);
   p_pwm_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'b110 |-> ref_o == (cnt_o >= cmp_val));
   p_pwm_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 3'b111 |-> ref_o == (cnt_o < cmp_val));
   p_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_PIN |-> pin_o == (pin_en && (ref_o ^ out_pol)));
endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W), .HAS_PIN(HAS_PIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .reload_val(reload_val), .cmp_val(cmp_val),
   .mode(mode), .out_pol(out_pol), .pin_en(pin_en), .preset_stb(preset_stb),
   .match_clr(match_clr), .upd_clr(upd_clr), .cnt_o(cnt_o), .ref_o(ref_o),
   .pin_o(pin_o), .match_flag(match_flag), .upd_flag(upd_flag)
);

// File: tb/tmr_oc_channel_bench.sv
module tmr_oc_channel_bench;
   localparam int CLK_P = 10;
   localparam int W = 8;
   localparam int NV = 10;
   // PWM walk: reload 4, compare 2
   localparam logic [2:0] T_MODE [NV] = '{3'd6,3'd6,3'd6,3'd6,3'd6,3'd7,3'd7,3'd7,3'd7,3'd7};
   localparam int         T_CNT  [NV] = '{0,1,2,3,4,0,1,2,3,4};
   localparam logic       T_REF  [NV] = '{0,0,1,1,1,1,1,0,0,0};
   localparam logic       T_MF   [NV] = '{0,0,0,1,1,1,1,1,1,1};
   localparam logic       T_UF   [NV] = '{0,0,0,0,0,1,1,1,1,1};

   logic clk = 1'b0;
   logic rst_n, en, out_pol, pin_en, preset_stb, preset_lvl, match_clr, upd_clr;
   logic [W-1:0] reload_val, cmp_val, cnt_o;
   logic [2:0] mode;
   logic ref_o, pin_o, match_flag, upd_flag;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   tmr_oc_channel #(.CNT_W(W)) u_tmr_oc_channel (
      .clk(clk), .rst_n(rst_n), .en(en), .reload_val(reload_val), .cmp_val(cmp_val),
      .mode(mode), .out_pol(out_pol), .pin_en(pin_en), .preset_stb(preset_stb),
      .preset_lvl(preset_lvl), .match_clr(match_clr), .upd_clr(upd_clr),
      .cnt_o(cnt_o), .ref_o(ref_o), .pin_o(pin_o), .match_flag(match_flag),
      .upd_flag(upd_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input int rl, input int cv, input logic [2:0] md);
      rst_n = 1'b0; en = 1'b0; out_pol = 1'b0; pin_en = 1'b1; preset_stb = 1'b0;
      preset_lvl = 1'b0; match_clr = 1'b0; upd_clr = 1'b0;
      reload_val = W'(rl); cmp_val = W'(cv); mode = md;
      tick(2);
      rst_n = 1'b1; en = 1'b1;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int c;
      int bad;
      // R11 reset state
      do_reset(4, 2, 3'd0);
      en = 1'b0; out_pol = 1'b1;
      rst_n = 1'b0; #1;
      chk("R11 cnt after reset", cnt_o, 0);
      chk("R11 ref after reset", ref_o, 0);
      chk("R11 flags after reset", {match_flag, upd_flag}, 0);
      chk("R10 pin inverted after reset", pin_o, 1);

      // R7 vector walk
      do_reset(4, 2, 3'd6);
      for (int i = 0; i < NV; i++) begin
         mode = T_MODE[i]; #1;
         chk($sformatf("R1 cnt vec %0d", i), cnt_o, T_CNT[i]);
         chk($sformatf("R7 ref vec %0d", i), ref_o, T_REF[i]);
         chk($sformatf("R10 pin vec %0d", i), pin_o, T_REF[i]);
         chk($sformatf("R3 match_flag vec %0d", i), match_flag, T_MF[i]);
         chk($sformatf("R2 upd_flag vec %0d", i), upd_flag, T_UF[i]);
         tick(1);
      end

      // R5 toggle, wrap ignored
      do_reset(9, 3, 3'd3);
      tick(4);
      chk("R5 toggle after match", ref_o, 1);
      tick(6);
      chk("R5 cnt at wrap", cnt_o, 0);
      chk("R5 wrap leaves toggle level", ref_o, 1);
      tick(4);
      chk("R5 second toggle", ref_o, 0);
      // R9 preset in compare mode
      preset_stb = 1'b1; preset_lvl = 1'b1;
      tick(1);
      preset_stb = 1'b0; #1;
      chk("R9 preset loads level", ref_o, 1);
      mode = 3'd2;
      tick(8);
      chk("R5 clear not before match", ref_o, 1);
      tick(1);
      chk("R5 clear on match", ref_o, 0);
      mode = 3'd1;
      tick(10);
      chk("R5 set on match", ref_o, 1);
      // R4 frozen
      mode = 3'd0;
      tick(12);
      chk("R4 frozen holds", ref_o, 1);
      preset_stb = 1'b1; preset_lvl = 1'b0;
      tick(1);
      preset_stb = 1'b0; #1;
      chk("R9 preset in frozen", ref_o, 0);
      // R6 forced
      mode = 3'd5; #1;
      chk("R6 force high", ref_o, 1);
      mode = 3'd4; #1;
      chk("R6 force low", ref_o, 0);
      preset_stb = 1'b1; preset_lvl = 1'b1;
      tick(1);
      preset_stb = 1'b0; mode = 3'd0; #1;
      chk("R9 preset ignored in forced mode", ref_o, 0);
      // R12
      mode = 3'd5;
      tick(1);
      mode = 3'd0;
      tick(3);
      chk("R12 frozen keeps forced level", ref_o, 1);
      // R1 hold
      en = 1'b0; c = cnt_o;
      tick(3);
      chk("R1 hold when disabled", cnt_o, c);
      // R10
      out_pol = 1'b0; #1;
      chk("R10 pin follows ref", pin_o, 1);
      out_pol = 1'b1; #1;
      chk("R10 pin inverted", pin_o, 0);
      out_pol = 1'b0; pin_en = 1'b0; #1;
      chk("R10 pin disconnected", pin_o, 0);

      // R8 compare beyond period
      do_reset(9, 12, 3'd6);
      bad = 0;
      for (int i = 0; i < 25; i++) begin
         if (ref_o !== 1'b0) bad++;
         tick(1);
      end
      chk("R8 PWM1 constant low", bad, 0);
      chk("R8 no match flag", match_flag, 0);
      mode = 3'd7; #1;
      chk("R8 PWM2 constant high", ref_o, 1);

      // R2/R3 clear and set-wins
      do_reset(3, 1, 3'd0);
      tick(2);
      chk("R3 match flag set", match_flag, 1);
      match_clr = 1'b1;
      tick(1);
      match_clr = 1'b0; #1;
      chk("R3 match flag cleared", match_flag, 0);
      chk("R2 no wrap yet", upd_flag, 0);
      upd_clr = 1'b1;
      tick(1);
      chk("R2 wrap wins over clear", upd_flag, 1);
      tick(1);
      upd_clr = 1'b0; #1;
      chk("R2 upd flag cleared", upd_flag, 0);
      match_clr = 1'b1;
      tick(1);
      match_clr = 1'b0; #1;
      chk("R3 match wins over clear", match_flag, 1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule